// File: doc/BRIEF.md
# Serial Flash Status and Write Guard

This block keeps the eight-bit status byte of a serial flash device and decides, one command at a time, whether a write-type operation may start. A command decoder gives it single-cycle strobes for set-write-enable, clear-write-enable, status write (with its data byte), page program, sector erase and full-array erase, together with the target address. The block also samples the level of the external write-protect pin and takes a completion pulse from the array timer when an internal cycle ends.

For each strobe the block answers with a one-cycle grant or reject pulse. A granted status write, program or erase raises the busy bit, and that bit stays up until the timer reports completion. The protection field divides the array into four equal sectors and blocks program and sector erase inside the protected range. A set lock bit together with a low protect pin freezes the lock and protection fields. Values that persist across power cycles are modelled only as reset values. If two strobes arrive in the same cycle, one is handled and the rest are dropped, in this order: status write, program, sector erase, full erase, set-enable, clear-enable.

Top module: `flash_guard`

## Requirements
- R1: After reset the status byte reads {RESET_LOCK, 000, RESET_BP, 0, 0}, and grant and reject are both 0.
- R2: When not busy, a set-enable strobe is granted and makes the enable bit (status bit 1) 1. A clear-enable strobe is granted and makes it 0.
- R3: When the enable bit is 0, status write, program, sector erase and full erase are rejected and the status byte does not change.
- R4: A granted status write copies data bit 7 into the lock bit (status bit 7) and data bits 3:2 into the protection field (status bits 3:2). It also sets the busy bit (status bit 0). Status bits 6:4 always read 0, and data bits 6:4 and 1:0 have no effect.
- R5: While the lock bit is 1 and the protect pin is low, a status write is rejected and the lock and protection fields hold. When the lock bit is 0, the pin level has no effect.
- R6: The protection field gates program and sector erase by address, with the sector index given by the two address MSBs. 00 protects nothing, 01 protects sector 3, 10 protects sectors 2 and 3, and 11 protects every sector. A command whose address falls in a protected sector is rejected.
- R7: Full erase is granted only when the protection field is 00.
- R8: A granted program or erase sets the busy bit, and the enable bit stays 1 while busy.
- R9: A completion pulse while busy clears both the busy bit and the enable bit on the next clock edge. A completion pulse while idle has no effect.
- R10: While busy, every command strobe is rejected and has no effect on the status byte.
- R11: A rejected command never changes the enable bit and never sets the busy bit.
- R12: Grant and reject are one-cycle pulses that appear on the clock edge after the strobe. They are never 1 together, and both are 0 in any cycle that follows a cycle with no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_we_i | input | 1 | Set-write-enable strobe |
| clr_we_i | input | 1 | Clear-write-enable strobe |
| sr_write_i | input | 1 | Status write strobe |
| sr_data_i | input | 8 | Status write data byte |
| program_i | input | 1 | Page program strobe |
| sect_erase_i | input | 1 | Sector erase strobe |
| full_erase_i | input | 1 | Full-array erase strobe |
| addr_i | input | ADDR_W | Target byte address for program and sector erase |
| wp_n_i | input | 1 | Write-protect pin level, low means protect |
| cycle_done_i | input | 1 | Completion pulse from the array timer |
| status_o | output | 8 | Status byte |
| grant_o | output | 1 | Command accepted pulse |
| reject_o | output | 1 | Command refused pulse |
| wel_o | output | 1 | Write-enable latch state |

## Verification
The checker watches several properties on every cycle. Grant and reject are never high together, and status bits 6:4 stay at zero. The busy bit rises only together with a grant and only when the enable bit was set. A completion pulse while busy clears both bits. A rejection with the busy bit clear leaves the low two status bits unchanged. The lock fields hold whenever the hardware lock was active, and full erase is refused whenever any protection bit is set. Other behaviour depends on a particular history of commands, so only the bench scenarios can show it. This covers the exact sector boundaries for each protection code, the bit-by-bit effect of a status write, the lock released by raising the pin, and the ordering of enable, busy and completion across a full program or erase.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_SET_WE,
        OP_CLR_WE,
        OP_SR_WRITE,
        OP_PROGRAM,
        OP_SECT_ERASE,
        OP_FULL_ERASE
    } guard_op_e;

    typedef struct packed {
        logic       lock;
        logic [1:0] prot;
        logic       wel;
        logic       busy;
        logic       grant;
        logic       reject;
    } guard_state_t;

    localparam int LOCK_BIT    = 7;
    localparam int PROT_HI_BIT = 3;
    localparam int PROT_LO_BIT = 2;

endpackage

// File: rtl/fg_op_pick.sv
module fg_op_pick
    import flash_guard_pkg::*;
(
    input  logic      set_we_i,
    input  logic      clr_we_i,
    input  logic      sr_write_i,
    input  logic      program_i,
    input  logic      sect_erase_i,
    input  logic      full_erase_i,
    output guard_op_e op_o
);
    always_comb begin
        if (sr_write_i)        op_o = OP_SR_WRITE;
        else if (program_i)    op_o = OP_PROGRAM;
        else if (sect_erase_i) op_o = OP_SECT_ERASE;
        else if (full_erase_i) op_o = OP_FULL_ERASE;
        else if (set_we_i)     op_o = OP_SET_WE;
        else if (clr_we_i)     op_o = OP_CLR_WE;
        else                   op_o = OP_NONE;
    end
endmodule

// File: rtl/fg_region.sv
module fg_region #(
    parameter int ADDR_W      = 17,
    parameter int SECTOR_BITS = 2
) (
    input  logic [1:0]        prot_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o
);
    localparam int SHIFT = ADDR_W - SECTOR_BITS;
    localparam logic [ADDR_W-1:0] TOP_LO  = {{SECTOR_BITS{1'b1}}, {SHIFT{1'b0}}};
    localparam logic [ADDR_W-1:0] HALF_LO = {1'b1, {(ADDR_W-1){1'b0}}};

    logic [ADDR_W-1:0] low_bound;

    always_comb begin
        case (prot_i)
            2'b01:   low_bound = TOP_LO;
            2'b10:   low_bound = HALF_LO;
            default: low_bound = '0;
        endcase
        hit_o = (prot_i != 2'b00) && (addr_i >= low_bound);
    end
endmodule

// File: rtl/flash_guard.sv
module flash_guard
    import flash_guard_pkg::*;
#(
    parameter int         ADDR_W      = 17,
    parameter int         SECTOR_BITS = 2,
    parameter logic       RESET_LOCK  = 1'b0,
    parameter logic [1:0] RESET_BP    = 2'b00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_we_i,
    input  logic              clr_we_i,
    input  logic              sr_write_i,
    input  logic [7:0]        sr_data_i,
    input  logic              program_i,
    input  logic              sect_erase_i,
    input  logic              full_erase_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wp_n_i,
    input  logic              cycle_done_i,
    output logic [7:0]        status_o,
    output logic              grant_o,
    output logic              reject_o,
    output logic              wel_o
);
    localparam guard_state_t RESET_STATE = '{
        lock: RESET_LOCK, prot: RESET_BP, wel: 1'b0, busy: 1'b0,
        grant: 1'b0, reject: 1'b0
    };

    guard_state_t state_q, state_d;
    guard_op_e    op;
    logic         region_hit;
    logic         hw_frozen;
    logic         unused_data_bits;

    assign unused_data_bits = ^{sr_data_i[6:4], sr_data_i[1:0]};

    fg_op_pick u_pick (
        .set_we_i     (set_we_i),
        .clr_we_i     (clr_we_i),
        .sr_write_i   (sr_write_i),
        .program_i    (program_i),
        .sect_erase_i (sect_erase_i),
        .full_erase_i (full_erase_i),
        .op_o         (op)
    );

    fg_region #(.ADDR_W(ADDR_W), .SECTOR_BITS(SECTOR_BITS)) u_region (
        .prot_i (state_q.prot),
        .addr_i (addr_i),
        .hit_o  (region_hit)
    );

    assign hw_frozen = state_q.lock & ~wp_n_i;

    always_comb begin
        state_d        = state_q;
        state_d.grant  = 1'b0;
        state_d.reject = 1'b0;
        if (state_q.busy) begin
            if (op != OP_NONE) state_d.reject = 1'b1;
            if (cycle_done_i) begin
                state_d.busy = 1'b0;
                state_d.wel  = 1'b0;
            end
        end else begin
            case (op)
                OP_SET_WE: begin
                    state_d.wel   = 1'b1;
                    state_d.grant = 1'b1;
                end
                OP_CLR_WE: begin
                    state_d.wel   = 1'b0;
                    state_d.grant = 1'b1;
                end
                OP_SR_WRITE: begin
                    if (state_q.wel && !hw_frozen) begin
                        state_d.lock  = sr_data_i[LOCK_BIT];
                        state_d.prot  = sr_data_i[PROT_HI_BIT:PROT_LO_BIT];
                        state_d.busy  = 1'b1;
                        state_d.grant = 1'b1;
                    end else begin
                        state_d.reject = 1'b1;
                    end
                end
                OP_PROGRAM, OP_SECT_ERASE: begin
                    if (state_q.wel && !region_hit) begin
                        state_d.busy  = 1'b1;
                        state_d.grant = 1'b1;
                    end else begin
                        state_d.reject = 1'b1;
                    end
                end
                OP_FULL_ERASE: begin
                    if (state_q.wel && state_q.prot == 2'b00) begin
                        state_d.busy  = 1'b1;
                        state_d.grant = 1'b1;
                    end else begin
                        state_d.reject = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RESET_STATE;
        else        state_q <= state_d;
    end

    assign status_o = {state_q.lock, 3'b000, state_q.prot, state_q.wel, state_q.busy};
    assign grant_o  = state_q.grant;
    assign reject_o = state_q.reject;
    assign wel_o    = state_q.wel;

endmodule

// File: rtl/flash_guard_chk.sv
module flash_guard_chk #(
    parameter int ADDR_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              set_we_i,
    input logic              clr_we_i,
    input logic              sr_write_i,
    input logic              program_i,
    input logic              sect_erase_i,
    input logic              full_erase_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              wp_n_i,
    input logic              cycle_done_i,
    input logic [7:0]        status_o,
    input logic              grant_o,
    input logic              reject_o,
    input logic              wel_o
);
    logic unused_chk;
    assign unused_chk = ^{addr_i, wel_o};

    assert_one_answer_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_o && reject_o));

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_we_i || clr_we_i || sr_write_i || program_i || sect_erase_i || full_erase_i)
        |=> !grant_o && !reject_o);

    assert_pad_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[6:4] == 3'b000);

    assert_busy_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[0]) |-> grant_o && $past(status_o[1]));

    assert_done_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[0] && cycle_done_i) |=> !status_o[0] && !status_o[1]);

    assert_reject_keeps_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (reject_o && !$past(status_o[0])) |-> status_o[1:0] == $past(status_o[1:0]));

    assert_lock_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[7] && !wp_n_i) |=> status_o[7] && $stable(status_o[3:2]));

    assert_full_erase_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (full_erase_i && !(sr_write_i || program_i || sect_erase_i)
         && status_o[3:2] != 2'b00) |=> reject_o);

endmodule

bind flash_guard flash_guard_chk #(.ADDR_W(ADDR_W)) chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .set_we_i     (set_we_i),
    .clr_we_i     (clr_we_i),
    .sr_write_i   (sr_write_i),
    .program_i    (program_i),
    .sect_erase_i (sect_erase_i),
    .full_erase_i (full_erase_i),
    .addr_i       (addr_i),
    .wp_n_i       (wp_n_i),
    .cycle_done_i (cycle_done_i),
    .status_o     (status_o),
    .grant_o      (grant_o),
    .reject_o     (reject_o),
    .wel_o        (wel_o)
);

// File: tb/flash_guard_test.sv
module flash_guard_test;
    localparam int AW = 17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          set_we_i = 1'b0, clr_we_i = 1'b0, sr_write_i = 1'b0;
    logic [7:0]    sr_data_i = '0;
    logic          program_i = 1'b0, sect_erase_i = 1'b0, full_erase_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic          wp_n_i = 1'b1;
    logic          cycle_done_i = 1'b0;
    logic [7:0]    status_o;
    logic          grant_o, reject_o, wel_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    typedef struct {
        logic [7:0] st;
        logic       g;
        logic       r;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    flash_guard #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n),
        .set_we_i(set_we_i), .clr_we_i(clr_we_i),
        .sr_write_i(sr_write_i), .sr_data_i(sr_data_i),
        .program_i(program_i), .sect_erase_i(sect_erase_i), .full_erase_i(full_erase_i),
        .addr_i(addr_i), .wp_n_i(wp_n_i), .cycle_done_i(cycle_done_i),
        .status_o(status_o), .grant_o(grant_o), .reject_o(reject_o), .wel_o(wel_o)
    );

    task automatic compare(exp_t e);
        checks++;
        if (status_o !== e.st || grant_o !== e.g || reject_o !== e.r || wel_o !== e.st[1]) begin
            fails++;
            $display("FAIL %s: status=%02h grant=%b reject=%b wel=%b, expected status=%02h grant=%b reject=%b",
                     e.tag, status_o, grant_o, reject_o, wel_o, e.st, e.g, e.r);
        end
    endtask

    // monitor: compares each registered result one half cycle after its edge
    always @(negedge clk) begin
        if (sb_q.size() > 0) compare(sb_q.pop_front());
    end

    // kind: 0 none, 1 set-enable, 2 clear-enable, 3 status write, 4 program, 5 sector erase, 6 full erase
    task automatic issue(int kind, logic [7:0] data, logic [AW-1:0] addr, logic done,
                         logic [7:0] est, logic g, logic r, string tag);
        exp_t e;
        @(negedge clk);
        set_we_i     = (kind == 1);
        clr_we_i     = (kind == 2);
        sr_write_i   = (kind == 3);
        program_i    = (kind == 4);
        sect_erase_i = (kind == 5);
        full_erase_i = (kind == 6);
        sr_data_i    = data;
        addr_i       = addr;
        cycle_done_i = done;
        @(posedge clk);
        #1;
        e.st = est; e.g = g; e.r = r; e.tag = tag;
        sb_q.push_back(e);
        {set_we_i, clr_we_i, sr_write_i, program_i, sect_erase_i, full_erase_i, cycle_done_i} = '0;
    endtask

    initial begin
        exp_t e0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        e0.st = 8'h00; e0.g = 1'b0; e0.r = 1'b0; e0.tag = "R1 reset state";
        compare(e0);

        issue(3, 8'hFF, '0, 0, 8'h00, 0, 1, "R3 status write without enable");
        issue(4, 8'h00, '0, 0, 8'h00, 0, 1, "R3 program without enable");
        issue(6, 8'h00, '0, 0, 8'h00, 0, 1, "R3 full erase without enable");
        issue(1, 8'h00, '0, 0, 8'h02, 1, 0, "R2 set enable");
        issue(2, 8'h00, '0, 0, 8'h00, 1, 0, "R2 clear enable");
        issue(1, 8'h00, '0, 0, 8'h02, 1, 0, "R2 set enable again");
        issue(3, 8'hFF, '0, 0, 8'h8F, 1, 0, "R4 status write all ones");
        issue(1, 8'h00, '0, 0, 8'h8F, 0, 1, "R10 set enable while busy");
        issue(5, 8'h00, '0, 0, 8'h8F, 0, 1, "R10 sector erase while busy");
        issue(0, 8'h00, '0, 1, 8'h8C, 0, 0, "R9 completion clears busy and enable");
        issue(0, 8'h00, '0, 1, 8'h8C, 0, 0, "R9 completion while idle ignored");
        issue(1, 8'h00, '0, 0, 8'h8E, 1, 0, "R2 set enable under lock");
        wp_n_i = 1'b0;
        issue(3, 8'h00, '0, 0, 8'h8E, 0, 1, "R5 R11 locked status write rejected");
        wp_n_i = 1'b1;
        issue(3, 8'hF7, '0, 0, 8'h87, 1, 0, "R4 pin high releases lock, pad bits ignored");
        issue(0, 8'h00, '0, 1, 8'h84, 0, 0, "R9 completion after status write");
        issue(1, 8'h00, '0, 0, 8'h86, 1, 0, "R2 enable for program");
        issue(4, 8'h00, 17'h1FFFF, 0, 8'h86, 0, 1, "R6 code 01 blocks top sector");
        issue(4, 8'h00, 17'h18000, 0, 8'h86, 0, 1, "R6 code 01 blocks top sector start");
        issue(6, 8'h00, '0, 0, 8'h86, 0, 1, "R7 full erase with code 01");
        issue(4, 8'h00, 17'h17FFF, 0, 8'h87, 1, 0, "R6 R8 code 01 program below top sector");
        issue(0, 8'h00, '0, 0, 8'h87, 0, 0, "R8 enable held while busy");
        issue(0, 8'h00, '0, 1, 8'h84, 0, 0, "R9 completion after program");
        issue(1, 8'h00, '0, 0, 8'h86, 1, 0, "R2 enable for status write");
        issue(3, 8'h08, '0, 0, 8'h0B, 1, 0, "R4 write code 10 and clear lock");
        issue(0, 8'h00, '0, 1, 8'h08, 0, 0, "R9 completion");
        issue(1, 8'h00, '0, 0, 8'h0A, 1, 0, "R2 enable for erase");
        issue(5, 8'h00, 17'h10000, 0, 8'h0A, 0, 1, "R6 code 10 blocks upper half");
        issue(5, 8'h00, 17'h0FFFF, 0, 8'h0B, 1, 0, "R6 code 10 erase lower half");
        issue(0, 8'h00, '0, 1, 8'h08, 0, 0, "R9 completion after erase");
        issue(1, 8'h00, '0, 0, 8'h0A, 1, 0, "R2 enable");
        issue(3, 8'h0C, '0, 0, 8'h0F, 1, 0, "R4 write code 11");
        issue(0, 8'h00, '0, 1, 8'h0C, 0, 0, "R9 completion");
        issue(1, 8'h00, '0, 0, 8'h0E, 1, 0, "R2 enable");
        issue(5, 8'h00, 17'h00000, 0, 8'h0E, 0, 1, "R6 code 11 blocks sector 0");
        wp_n_i = 1'b0;
        issue(3, 8'h00, '0, 0, 8'h03, 1, 0, "R5 lock clear so pin low has no effect");
        wp_n_i = 1'b1;
        issue(0, 8'h00, '0, 1, 8'h00, 0, 0, "R9 completion");
        issue(1, 8'h00, '0, 0, 8'h02, 1, 0, "R2 enable");
        issue(6, 8'h00, '0, 0, 8'h03, 1, 0, "R7 full erase with code 00");
        issue(0, 8'h00, '0, 1, 8'h00, 0, 0, "R9 completion after full erase");
        issue(0, 8'h00, '0, 0, 8'h00, 0, 0, "R12 no strobe no answer");
        issue(2, 8'h00, '0, 0, 8'h00, 1, 0, "R2 clear enable when already clear");

        @(negedge clk);
        @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: cycles=%0d expected completion before 20000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule